// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small processor core that retires one instruction on every rising clock edge. It holds the program counter, the decoder with its main control, a bank of thirty-two 32-bit general registers, an arithmetic/logic unit with a zero flag, and the immediate extenders. It runs a ten-instruction integer subset: register add, subtract, and, or and signed set-less-than, or-immediate, word load, word store, branch-on-equal and an absolute jump.

The core fetches through a combinational instruction port: it drives the address and the word comes back in the same cycle. It reaches data through a port with an address, write data, a write strobe and combinational read data. Both memories sit outside the core. The surrounding system, or a testbench, loads them. Register reads are combinational. Register and memory writes, and the program counter update, all take effect on the same rising edge.

Top module: `core_top`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0. The reset acts asynchronously. Every instruction other than a taken branch or a jump advances imem_addr_o by 4 on the next rising edge.
- R2: With opcode field [31:26] = 0, the funct field [5:0] selects the operation, and the result goes to the register in bits [15:11]. The codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or and 0x2A set-less-than. The two sources come from bits [25:21] (first) and [20:16] (second). Add and subtract wrap modulo 2^32.
- R3: Set-less-than writes 1 when the first source is below the second as a signed value, and 0 otherwise, including when the two are equal.
- R4: Opcode 0x0D writes the first source OR the zero-extended 16-bit field [15:0] into the register in bits [20:16].
- R5: Opcode 0x23 (load) writes the data word at address (first source + sign-extended [15:0]) into the register in bits [20:16]. Opcode 0x2B (store) drives that same address with dmem_we_o high and the [20:16] register on dmem_wdata_o. dmem_we_o is high for stores only.
- R6: Opcode 0x04 compares the two source registers. If they are equal, the next PC is PC+4 plus the sign-extended [15:0] shifted left by two; if not, it is PC+4.
- R7: Opcode 0x02 loads the PC with bits [31:28] of PC+4, then field [25:0], then two zero bits.
- R8: Register 0 always reads as zero, and any write aimed at it has no effect.
- R9: Any other opcode, and any unlisted funct under opcode 0, completes as a no-op: no register or memory write, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 32 | Byte address of the current instruction (the PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address for load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Word read at dmem_addr_o |
| dmem_we_o | output | 1 | Store strobe, taken on the rising edge |

## Verification
Register contents are invisible at the ports. Each scenario therefore ends in stores, and the bench reads those stores back from its own data array. The hardest case to reach is a change of control flow whose effect shows only in the instruction sequence. Examples are a branch that is not taken because one operand is register 0, a backward branch with a negative offset, and a skipped instruction that would otherwise have overwritten a register. The branch program places a poison instruction in the skipped slot, loops back through a store, and samples the PC after every edge. The register-0 case writes to register 0 twice, then stores it and uses it as an or-immediate source.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    imm_zext;
    logic    load;
    logic    store;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;  // unlisted funct: no-op
        endcase
      end
      OP_ORI: begin
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.src_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
        ctrl_o.alu_op   = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.load    = 1'b1;
      end
      OP_SW: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.store   = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = W'($signed(a_i) < $signed(b_i));
      default: res_o = '0;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs_q [N];

  // entry 0 is cleared by reset and never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < N; i++)
        if (we_i && waddr_i == AW'(i)) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            dmem_we_o
);
  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
  logic [5:0]        op, funct;
  logic [RIDX_W-1:0] rs, rt, rd, waddr;
  logic [15:0]       imm16;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_res, wb_data;
  logic              alu_zero;
  ctrl_t             ctrl;
  logic              unused_shamt;

  assign op           = imem_data_i[31:26];
  assign rs           = imem_data_i[25:21];
  assign rt           = imem_data_i[20:16];
  assign rd           = imem_data_i[15:11];
  assign funct        = imem_data_i[5:0];
  assign imm16        = imem_data_i[15:0];
  assign unused_shamt = ^imem_data_i[10:6];

  core_ctrl u_ctrl (
    .op_i    (op),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  assign imm_ext = ctrl.imm_zext ? {{(XLEN-16){1'b0}}, imm16}
                                 : {{(XLEN-16){imm16[15]}}, imm16};
  assign waddr   = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.load ? dmem_rdata_i : alu_res;

  core_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl.reg_we),
    .waddr_i   (waddr),
    .wdata_i   (wb_data),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  core_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // dedicated target adders keep the ALU free for the compare
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:28], imem_data_i[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    pc_next = jmp_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_res;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctrl.store;
endmodule

// File: rtl/core_chk.sv
module core_chk
  import core_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] imem_addr_o,
  input logic [XLEN-1:0] imem_data_i,
  input logic [XLEN-1:0] dmem_wdata_o,
  input logic            dmem_we_o
);
  logic [5:0]      op;
  logic [XLEN-1:0] pc4, taken_tgt, jump_tgt;

  assign op        = imem_data_i[31:26];
  assign pc4       = imem_addr_o + 32'd4;
  assign taken_tgt = pc4 + {{14{imem_data_i[15]}}, imem_data_i[15:0], 2'b00};
  assign jump_tgt  = {pc4[31:28], imem_data_i[25:0], 2'b00};

  a_r1_reset_pc: assert property (@(posedge clk_i) !rst_ni |-> imem_addr_o == '0);

  a_r1_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> imem_addr_o == $past(pc4));

  a_r5_we_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> op == OP_SW);

  a_r5_store_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_SW |-> dmem_we_o);

  a_r6_equal_regs_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && imem_data_i[25:21] == imem_data_i[20:16])
      |=> imem_addr_o == $past(taken_tgt));

  a_r7_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_J |=> imem_addr_o == $past(jump_tgt));

  a_r8_zero_reg_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o && imem_data_i[20:16] == 5'd0) |-> dmem_wdata_o == '0);
endmodule

bind core_top core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_o  (imem_addr_o),
  .imem_data_i  (imem_data_i),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_we_o    (dmem_we_o)
);

// File: tb/core_top_tb_top.sv
`timescale 1ns/1ps
module core_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  core_top dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .dmem_we_o    (dmem_we)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (ld_we)                dmem[ld_addr] <= ld_data;
    else if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] j_op(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // enter reset, clear program and data, leave reset held
  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    ld_we = 1'b1;
    for (int i = 0; i < 64; i++) begin
      ld_addr = 6'(i); ld_data = 32'h0;
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic preload(int idx, logic [31:0] val);
    ld_we = 1'b1; ld_addr = 6'(idx); ld_data = val;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_run(int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    imem[0] = it_op(6'h0D, 0, 1, 16'h1);
    imem[1] = it_op(6'h0D, 0, 2, 16'h2);
    imem[2] = it_op(6'h0D, 0, 3, 16'h3);
    chk("R1 pc in reset", imem_addr, 32'h0);
    release_run(3);
    chk("R1 pc after 3 steps", imem_addr, 32'hC);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset pc", imem_addr, 32'h0);
  endtask

  task automatic t_arith();
    hold_reset();
    imem[0]  = it_op(6'h0D, 0, 1, 16'h8000);
    imem[1]  = it_op(6'h0D, 0, 2, 16'h0003);
    imem[2]  = rt_op(1, 2, 3, 6'h20);
    imem[3]  = rt_op(2, 1, 4, 6'h22);
    imem[4]  = rt_op(1, 2, 5, 6'h24);
    imem[5]  = rt_op(1, 2, 6, 6'h25);
    imem[6]  = rt_op(4, 2, 7, 6'h2A);
    imem[7]  = rt_op(2, 4, 8, 6'h2A);
    imem[8]  = it_op(6'h0D, 0, 9, 16'hFFFF);
    imem[9]  = rt_op(2, 2, 10, 6'h2A);
    for (int k = 0; k < 8; k++) imem[10+k] = it_op(6'h2B, 0, 3+k, 16'(4*k));
    imem[18] = it_op(6'h2B, 0, 1, 16'h0020);
    release_run(19);
    chk("R2 add", dmem[0], 32'h0000_8003);
    chk("R2 sub wraps", dmem[1], 32'hFFFF_8003);
    chk("R2 and", dmem[2], 32'h0);
    chk("R2 or", dmem[3], 32'h0000_8003);
    chk("R3 slt neg<pos", dmem[4], 32'h1);
    chk("R3 slt pos<neg", dmem[5], 32'h0);
    chk("R4 ori zero-ext ffff", dmem[6], 32'h0000_FFFF);
    chk("R3 slt equal", dmem[7], 32'h0);
    chk("R4 ori zero-ext 8000", dmem[8], 32'h0000_8000);
  endtask

  task automatic t_zero_reg();
    hold_reset();
    preload(0, 32'hDEAD_BEEF);
    imem[0] = it_op(6'h0D, 0, 1, 16'h0007);
    imem[1] = it_op(6'h0D, 0, 0, 16'h0055);
    imem[2] = rt_op(1, 1, 0, 6'h20);
    imem[3] = it_op(6'h2B, 0, 0, 16'h0000);
    imem[4] = it_op(6'h0D, 0, 2, 16'h0001);
    imem[5] = it_op(6'h2B, 0, 2, 16'h0004);
    release_run(6);
    chk("R8 r0 stored as zero", dmem[0], 32'h0);
    chk("R8 r0 as source", dmem[1], 32'h1);
  endtask

  task automatic t_mem();
    hold_reset();
    preload(20, 32'hCAFE_BABE);
    preload(21, 32'h1234_5678);
    imem[0] = it_op(6'h0D, 0, 1, 16'h0060);
    imem[1] = it_op(6'h23, 1, 2, 16'hFFF0);
    imem[2] = it_op(6'h23, 1, 3, 16'hFFF4);
    imem[3] = it_op(6'h2B, 1, 2, 16'h0004);
    imem[4] = it_op(6'h2B, 1, 3, 16'h0008);
    imem[5] = rt_op(2, 3, 4, 6'h20);
    imem[6] = it_op(6'h2B, 1, 4, 16'h000C);
    release_run(1);
    chk("R5 no strobe on load", {31'b0, dmem_we}, 32'h0);
    chk("R5 load address neg offset", dmem_addr, 32'h50);
    repeat (2) @(negedge clk);
    chk("R5 store strobe", {31'b0, dmem_we}, 32'h1);
    chk("R5 store address", dmem_addr, 32'h64);
    repeat (4) @(negedge clk);
    chk("R5 load then store", dmem[25], 32'hCAFE_BABE);
    chk("R5 second load", dmem[26], 32'h1234_5678);
    chk("R5 loaded operands", dmem[27], 32'hDD33_1136);
  endtask

  task automatic t_branch();
    hold_reset();
    preload(0, 32'hFFFF_FFFF);
    imem[0] = it_op(6'h0D, 0, 1, 16'h0007);
    imem[1] = it_op(6'h0D, 0, 2, 16'h0007);
    imem[2] = it_op(6'h04, 1, 2, 16'h0002);
    imem[3] = it_op(6'h0D, 0, 3, 16'h0BAD);
    imem[4] = it_op(6'h2B, 0, 3, 16'h0000);
    imem[5] = it_op(6'h04, 1, 0, 16'h0005);
    imem[6] = it_op(6'h04, 0, 0, 16'hFFFD);
    release_run(3);
    chk("R6 taken forward", imem_addr, 32'h14);
    @(negedge clk);
    chk("R6 not taken", imem_addr, 32'h18);
    @(negedge clk);
    chk("R6 taken backward", imem_addr, 32'h10);
    @(negedge clk);
    chk("R6 skipped slot not run", dmem[0], 32'h0);
  endtask

  task automatic t_jump();
    hold_reset();
    imem[0]  = it_op(6'h0D, 0, 1, 16'h0009);
    imem[1]  = j_op(26'h10);
    imem[2]  = it_op(6'h0D, 0, 1, 16'h0BAD);
    imem[16] = it_op(6'h2B, 0, 1, 16'h0000);
    imem[17] = j_op(26'h0);
    release_run(2);
    chk("R7 jump target", imem_addr, 32'h40);
    repeat (2) @(negedge clk);
    chk("R7 jump to zero", imem_addr, 32'h0);
    chk("R7 slot after jump skipped", dmem[0], 32'h9);
  endtask

  task automatic t_unknown();
    hold_reset();
    imem[0] = it_op(6'h0D, 0, 1, 16'h1234);
    imem[1] = it_op(6'h3F, 0, 1, 16'hFFFF);
    imem[2] = rt_op(0, 0, 1, 6'h03);
    imem[3] = it_op(6'h2B, 0, 1, 16'h0000);
    release_run(1);
    chk("R9 no strobe on unknown op", {31'b0, dmem_we}, 32'h0);
    @(negedge clk);
    chk("R9 pc advances", imem_addr, 32'h8);
    repeat (2) @(negedge clk);
    chk("R9 register untouched", dmem[0], 32'h0000_1234);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_zero_reg();
    t_mem();
    t_branch();
    t_jump();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule